// File: doc/BRIEF.md
# Segmented Paging Address Translator

This block turns a virtual address from a processor into a physical address. The low bits of the address are a byte offset within a page. The remaining bits form the virtual page number. The top bits of that page number pick one of several segments. The rest of the page number is a page index inside that segment.

Each segment keeps a small page table in internal registers, plus a length register that gives how many of its pages are currently mapped. A table entry is a present bit and a physical frame number. A lookup first checks the page index against the segment's length. If that check passes, it then checks the entry's present bit. The lookup returns one of three results: a physical address, a page fault (the page is not resident), or a bounds fault (the index is outside the mapped part of the segment).

Software fills the tables and lengths through a single write port. Each segment can grow on its own without touching the others.

Top module: `vaddr_xlat`

## Requirements
- R1: After a synchronous active-high reset, `resp_valid` is 0, every length is 0 and every entry is non-present, so every lookup returns a bounds fault.
- R2: `req_ready` is 1 outside reset. A request accepted at a clock edge gives `resp_valid`=1 after that same edge, and `resp_valid` is 0 after an edge with no request.
- R3: The segment is `req_vaddr[VA_W-1 -: SEG_W]` (default bits 31:30). The page index is the bits between the segment and the offset (default 29:12). The offset is `req_vaddr[OFF_W-1:0]` (default 11:0) and is copied unchanged into `resp_paddr[OFF_W-1:0]` on success.
- R4: A page index below the segment length, whose entry is present, gives `resp_paddr` = {frame number, offset} with both fault flags 0.
- R5: A page index below the segment length, whose entry is non-present, gives `resp_page_fault`=1, `resp_bounds_fault`=0 and `resp_paddr`=0.
- R6: A page index at or above the segment length gives `resp_bounds_fault`=1, `resp_page_fault`=0 and `resp_paddr`=0, whatever the entry holds. The bounds check takes priority.
- R7: `resp_page_fault` and `resp_bounds_fault` are never both 1.
- R8: A write changes only the segment named by `wr_seg`. Lookups in the other segments are unchanged.
- R9: A length write with `wr_kind`=1 and a value above the table depth (default 16) stores the depth.
- R10: A write takes effect for requests accepted at later edges. A request accepted at the same edge as the write sees the old contents.
- R11: A page index at or beyond the table depth (including any nonzero index bit above the table index) is always a bounds fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted (1 outside reset) |
| req_vaddr | input | VA_W | Virtual address |
| wr_en | input | 1 | Write strobe |
| wr_kind | input | 1 | 0 = page entry, 1 = length |
| wr_seg | input | SEG_W | Segment written |
| wr_idx | input | IDX_W | Entry index written |
| wr_pte_valid | input | 1 | Present bit for entry writes |
| wr_pfn | input | PFN_W | Frame number for entry writes |
| wr_len | input | IDX_W+1 | Length value for length writes |
| resp_valid | output | 1 | Response present |
| resp_paddr | output | PFN_W+OFF_W | Physical address, 0 on a fault |
| resp_page_fault | output | 1 | Entry not present |
| resp_bounds_fault | output | 1 | Index outside segment length |

## Verification
The assertions assume that `req_vaddr` holds steady for the cycle in which `req_valid` is sampled. They also assume that `rst` is held for at least two edges before any traffic, so that the past values they compare against are defined. The stimulus drives all inputs only on falling edges and holds reset for several cycles. It issues at most one write per cycle, sometimes in the same cycle as a request, which exercises the read-before-write ordering without breaking these assumptions.

// File: rtl/xlat_pkg.sv
package xlat_pkg;
    typedef enum logic [1:0] {
        XS_OK     = 2'd0,
        XS_PAGE   = 2'd1,
        XS_BOUNDS = 2'd2
    } xlat_status_e;

    typedef enum logic {
        WK_ENTRY  = 1'b0,
        WK_LENGTH = 1'b1
    } wr_kind_e;

    function automatic xlat_status_e classify(input logic in_bounds, input logic present);
        if (!in_bounds)    return XS_BOUNDS;
        else if (!present) return XS_PAGE;
        else               return XS_OK;
    endfunction
endpackage

// File: rtl/xlat_seg_table.sv
module xlat_seg_table #(
    parameter int SEG_W  = 2,
    parameter int IDX_W  = 4,
    parameter int PFN_W  = 20,
    parameter int SEG_ID = 0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic             wr_kind,
    input  logic [SEG_W-1:0] wr_seg,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_pte_valid,
    input  logic [PFN_W-1:0] wr_pfn,
    input  logic [IDX_W:0]   wr_len,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_present,
    output logic [PFN_W-1:0] rd_pfn,
    output logic [IDX_W:0]   len
);
    import xlat_pkg::*;
    localparam int DEPTH = 1 << IDX_W;
    localparam logic [SEG_W-1:0] MY_SEG = SEG_ID[SEG_W-1:0];
    localparam logic [IDX_W:0]   MAX_LEN = DEPTH[IDX_W:0];

    logic [DEPTH-1:0] present_q;
    logic [PFN_W-1:0] pfn_q [DEPTH];
    logic [IDX_W:0]   len_q;
    logic             hit;

    assign hit = wr_en && (wr_seg == MY_SEG);

    always_ff @(posedge clk) begin
        if (rst) begin
            present_q <= '0;
            len_q     <= '0;
        end else if (hit) begin
            if (wr_kind == WK_LENGTH)
                len_q <= (wr_len > MAX_LEN) ? MAX_LEN : wr_len;
            else
                present_q[wr_idx] <= wr_pte_valid;
        end
    end

    for (genvar e = 0; e < DEPTH; e++) begin : g_pfn
        always_ff @(posedge clk) begin
            if (hit && wr_kind == WK_ENTRY && wr_idx == e[IDX_W-1:0])
                pfn_q[e] <= wr_pfn;
        end
    end

    assign rd_present = present_q[rd_idx];
    assign rd_pfn     = pfn_q[rd_idx];
    assign len        = len_q;

    // R1
    len_after_reset_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (len_q == '0 && present_q == '0));

    // R8
    len_untouched_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(hit)) |-> ($stable(len_q) && $stable(present_q)));
endmodule

// File: rtl/xlat_check.sv
module xlat_check #(
    parameter int PIDX_W = 18,
    parameter int IDX_W  = 4,
    parameter int PFN_W  = 20,
    parameter int OFF_W  = 12
) (
    input  logic [PIDX_W-1:0]      pidx,
    input  logic [IDX_W:0]         len,
    input  logic                   present,
    input  logic [PFN_W-1:0]       pfn,
    input  logic [OFF_W-1:0]       off,
    output xlat_pkg::xlat_status_e status,
    output logic [PFN_W+OFF_W-1:0] paddr
);
    import xlat_pkg::*;
    logic [PIDX_W-1:0] len_ext;
    logic              in_bounds;

    assign len_ext   = {{(PIDX_W-IDX_W-1){1'b0}}, len};
    assign in_bounds = pidx < len_ext;
    assign status    = classify(in_bounds, present);
    assign paddr     = (status == XS_OK) ? {pfn, off} : '0;
endmodule

// File: rtl/vaddr_xlat.sv
module vaddr_xlat #(
    parameter int VA_W  = 32,
    parameter int OFF_W = 12,
    parameter int SEG_W = 2,
    parameter int IDX_W = 4,
    parameter int PFN_W = 20
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   req_valid,
    output logic                   req_ready,
    input  logic [VA_W-1:0]        req_vaddr,
    input  logic                   wr_en,
    input  logic                   wr_kind,
    input  logic [SEG_W-1:0]       wr_seg,
    input  logic [IDX_W-1:0]       wr_idx,
    input  logic                   wr_pte_valid,
    input  logic [PFN_W-1:0]       wr_pfn,
    input  logic [IDX_W:0]         wr_len,
    output logic                   resp_valid,
    output logic [PFN_W+OFF_W-1:0] resp_paddr,
    output logic                   resp_page_fault,
    output logic                   resp_bounds_fault
);
    import xlat_pkg::*;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PIDX_W = VPN_W - SEG_W;
    localparam int NSEG   = 1 << SEG_W;
    localparam int PA_W   = PFN_W + OFF_W;

    logic [SEG_W-1:0]  seg;
    logic [PIDX_W-1:0] pidx;
    logic [OFF_W-1:0]  off;
    logic              t_present [NSEG];
    logic [PFN_W-1:0]  t_pfn     [NSEG];
    logic [IDX_W:0]    t_len     [NSEG];
    xlat_status_e      status;
    logic [PA_W-1:0]   paddr_c;

    assign seg  = req_vaddr[VA_W-1 -: SEG_W];
    assign pidx = req_vaddr[OFF_W +: PIDX_W];
    assign off  = req_vaddr[OFF_W-1:0];
    assign req_ready = ~rst;

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        xlat_seg_table #(
            .SEG_W(SEG_W), .IDX_W(IDX_W), .PFN_W(PFN_W), .SEG_ID(g)
        ) u_tab (
            .clk(clk), .rst(rst),
            .wr_en(wr_en), .wr_kind(wr_kind), .wr_seg(wr_seg), .wr_idx(wr_idx),
            .wr_pte_valid(wr_pte_valid), .wr_pfn(wr_pfn), .wr_len(wr_len),
            .rd_idx(pidx[IDX_W-1:0]),
            .rd_present(t_present[g]), .rd_pfn(t_pfn[g]), .len(t_len[g])
        );
    end

    xlat_check #(
        .PIDX_W(PIDX_W), .IDX_W(IDX_W), .PFN_W(PFN_W), .OFF_W(OFF_W)
    ) u_check (
        .pidx(pidx), .len(t_len[seg]), .present(t_present[seg]),
        .pfn(t_pfn[seg]), .off(off), .status(status), .paddr(paddr_c)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_valid        <= 1'b0;
            resp_paddr        <= '0;
            resp_page_fault   <= 1'b0;
            resp_bounds_fault <= 1'b0;
        end else begin
            resp_valid        <= req_valid;
            resp_paddr        <= req_valid ? paddr_c : '0;
            resp_page_fault   <= req_valid && (status == XS_PAGE);
            resp_bounds_fault <= req_valid && (status == XS_BOUNDS);
        end
    end

    // R7
    one_fault_chk: assert property (@(posedge clk) disable iff (rst)
        !(resp_page_fault && resp_bounds_fault));

    // R2
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (resp_valid == $past(req_valid)));

    // R3
    offset_copy_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && resp_valid && !resp_page_fault && !resp_bounds_fault)
        |-> (resp_paddr[OFF_W-1:0] == $past(req_vaddr[OFF_W-1:0])));

    // R5
    fault_zero_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (resp_page_fault || resp_bounds_fault) |-> (resp_paddr == '0));

    // R11
    beyond_depth_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(req_valid) && ($past(pidx) >> IDX_W) != '0) |-> resp_bounds_fault);
endmodule

// File: tb/vaddr_xlat_tb.sv
module vaddr_xlat_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NSEG  = 4;
    localparam int DEPTH = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_vaddr = '0;
    logic        wr_en = 1'b0;
    logic        wr_kind = 1'b0;
    logic [1:0]  wr_seg = '0;
    logic [3:0]  wr_idx = '0;
    logic        wr_pte_valid = 1'b0;
    logic [19:0] wr_pfn = '0;
    logic [4:0]  wr_len = '0;
    logic        resp_valid;
    logic [31:0] resp_paddr;
    logic        resp_page_fault;
    logic        resp_bounds_fault;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    int          m_len [NSEG];
    bit          m_v   [NSEG][DEPTH];
    logic [19:0] m_pfn [NSEG][DEPTH];

    always #(CLK_PERIOD/2) clk = ~clk;

    vaddr_xlat dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_vaddr(req_vaddr), .wr_en(wr_en), .wr_kind(wr_kind), .wr_seg(wr_seg),
        .wr_idx(wr_idx), .wr_pte_valid(wr_pte_valid), .wr_pfn(wr_pfn), .wr_len(wr_len),
        .resp_valid(resp_valid), .resp_paddr(resp_paddr),
        .resp_page_fault(resp_page_fault), .resp_bounds_fault(resp_bounds_fault)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic write_pte(input int s, input int i, input bit v, input logic [19:0] p);
        @(negedge clk);
        wr_en = 1; wr_kind = 0; wr_seg = 2'(s); wr_idx = 4'(i); wr_pte_valid = v; wr_pfn = p;
        @(negedge clk);
        wr_en = 0;
        m_v[s][i] = v; m_pfn[s][i] = p;
    endtask

    task automatic write_len(input int s, input int l);
        @(negedge clk);
        wr_en = 1; wr_kind = 1; wr_seg = 2'(s); wr_len = 5'(l);
        @(negedge clk);
        wr_en = 0;
        m_len[s] = (l > DEPTH) ? DEPTH : l;
    endtask

    function automatic logic [31:0] mkva(input int s, input int pidx, input int off);
        return {2'(s), 18'(pidx), 12'(off)};
    endfunction

    task automatic lookup(input int s, input int pidx, input int off);
        logic [31:0] exp_pa;
        bit exp_pf, exp_bf;
        @(negedge clk);
        req_valid = 1; req_vaddr = mkva(s, pidx, off);
        @(negedge clk);
        req_valid = 0;
        exp_bf = (pidx >= m_len[s]);
        exp_pf = !exp_bf && !m_v[s][pidx % DEPTH];
        exp_pa = (exp_bf || exp_pf) ? 32'h0 : {m_pfn[s][pidx % DEPTH], 12'(off)};
        check("R2 resp_valid", 64'(resp_valid), 64'd1);
        check("R7 single fault", 64'(resp_page_fault & resp_bounds_fault), 64'd0);
        if (exp_bf) begin
            check("R6 bounds flag", 64'(resp_bounds_fault), 64'd1);
            if (pidx >= DEPTH) check("R11 beyond depth", 64'(resp_bounds_fault), 64'd1);
        end else if (exp_pf) begin
            check("R5 page flag", 64'(resp_page_fault), 64'd1);
        end else begin
            check("R4 paddr", 64'(resp_paddr), 64'(exp_pa));
            check("R3 offset", 64'(resp_paddr[11:0]), 64'(off));
        end
        check("R4 paddr/flags", {30'b0, resp_page_fault, resp_bounds_fault, resp_paddr},
              {30'b0, exp_pf, exp_bf, exp_pa});
    endtask

    task automatic sweep();
        for (int s = 0; s < NSEG; s++) begin
            for (int p = 0; p < DEPTH + 3; p++)
                lookup(s, p, (s * 257 + p * 31) & 12'hfff);
            lookup(s, 18'h3ffff, 12'h5a5);
            lookup(s, 18'h20003, 12'h001);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int s = 0; s < NSEG; s++) begin
            m_len[s] = 0;
            for (int i = 0; i < DEPTH; i++) begin m_v[s][i] = 0; m_pfn[s][i] = '0; end
        end
        repeat (4) @(negedge clk);
        check("R1 resp_valid in reset", 64'(resp_valid), 64'd0);
        rst = 0;
        @(negedge clk);
        check("R1 resp_valid after reset", 64'(resp_valid), 64'd0);
        check("R2 req_ready", 64'(req_ready), 64'd1);
        // R1: everything bounds-faults before loading
        for (int s = 0; s < NSEG; s++) lookup(s, 0, 12'h123);
        @(negedge clk);
        check("R2 idle resp_valid", 64'(resp_valid), 64'd0);

        // load tables; R9 via segment 3 length 31
        for (int s = 0; s < NSEG; s++)
            for (int i = 0; i < DEPTH; i++)
                write_pte(s, i, ((s + i) % 3) != 0, 20'(s * 4096 + i * 97 + 3));
        write_len(0, 5);
        write_len(1, 16);
        write_len(2, 0);
        write_len(3, 31); // R9 saturates to 16
        sweep();
        lookup(3, 20, 12'h0ab); // R9: would hit entry 4 without saturation

        // R8: change segment 1 only, recheck all segments
        write_len(1, 2);
        write_pte(1, 1, 0, 20'h0);
        sweep();

        // R10: write and request in the same cycle
        write_pte(2, 0, 1, 20'habcde);
        @(negedge clk);
        wr_en = 1; wr_kind = 1; wr_seg = 2'd2; wr_len = 5'd4;
        req_valid = 1; req_vaddr = mkva(2, 0, 12'h777);
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        check("R10 old length seen", 64'(resp_bounds_fault), 64'd1);
        m_len[2] = 4;
        lookup(2, 0, 12'h777);
        check("R10 new length seen", 64'(resp_paddr), 64'({20'habcde, 12'h777}));

        // R1: reset again clears tables
        @(negedge clk); rst = 1;
        repeat (2) @(negedge clk); rst = 0;
        for (int s = 0; s < NSEG; s++) m_len[s] = 0;
        lookup(1, 0, 12'h010);
        check("R1 bounds after reset", 64'(resp_bounds_fault), 64'd1);

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule